// File: doc/BRIEF.md
# Two-Wire Bus Controller Control Logic

This block is the control-register and event logic for a two-wire (I2C-style) bus controller that can act as master or as slave. Software writes one byte-wide control register. The block turns that register and the status reported by a separate bus engine into start, repeated-start and stop commands, an acknowledge value for receive cycles, a general-call match indication, a stall-after-start status and one interrupt line. The bit-level engine, the clock generation and the address comparator sit outside the block. They report their state through level and pulse inputs.

Several bits clear themselves when hardware completes the matching action, and every bit reads back its live value. The start request acts in one of two ways. When the controller is not yet bus master, it waits for the bus to become free. When the controller already owns the bus, the next data-register write becomes a repeated start, and that byte is sent as the address and direction. The interrupt combines every pending event source, gated by the enable bits. It can be built as a combinational output or as a registered output.

Top module: `twi_ctl_core`

## Requirements
- R1: After reset the control register reads 0x00. Its layout is bit 0 start request, bit 1 stop request, bit 2 interrupt enable, bit 3 reserved, bit 4 acknowledge override, bit 5 general-call enable, bit 6 match-interrupt enable and bit 7 stall-after-start enable. Bit 3 always reads 0 and ignores writes. Bits 0, 1, 2, 5, 6 and 7 load the written value, and each bit reads back its current value.
- R2: `cmd_start` is high exactly while the start bit is set, `is_master` is low and `bus_busy` is low.
- R3: When the start bit is set and `is_master` is high, a `dat_wr` pulse makes `cmd_repstart` high for exactly one cycle, on the cycle after the write. `dat_wr` gives no pulse when the start bit is clear or when `is_master` is low.
- R4: The start bit clears on the cycle after `start_done` or `bus_err` is high. This hardware clear wins over a software write in the same cycle.
- R5: `cmd_stop` is high exactly while the stop bit is set and `is_master` is high. The stop bit clears on the cycle after `stop_done`.
- R6: `irq` equals interrupt enable ANDed with the OR of these sources: a match (address match or general-call match) with match-interrupt enable set, `bus_err`, `nack_rx`, `data_ready`, the stall flag, and `slave_stop`.
- R7: Writing 1 to bit 4 sets the acknowledge override. Writing 0 to it has no effect. It clears on the cycle after `ack_done`. `ack_value` (1 = negative acknowledge) equals the override ANDed with `rx_mode`, so the override is ignored while transmitting.
- R8: `gcall_match` equals `gcall_seen` AND general-call enable AND NOT `is_master`. With the enable clear, a general call raises neither `gcall_match` nor an interrupt.
- R9: `stall_flag` equals `start_ok` AND stall-after-start enable AND `is_master`. It is forced to 0 while the enable is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Live control register value |
| dat_wr | input | 1 | Data register write strobe (address byte on a repeated start) |
| bus_busy | input | 1 | Engine reports that the bus is occupied |
| is_master | input | 1 | Engine reports that this controller owns the bus |
| rx_mode | input | 1 | Engine is receiving data bytes |
| start_done | input | 1 | Pulse: start condition has been sent |
| stop_done | input | 1 | Pulse: stop condition has been issued |
| ack_done | input | 1 | Pulse: an acknowledge cycle has completed |
| bus_err | input | 1 | Bus error pending |
| nack_rx | input | 1 | Negative acknowledge received after a sent byte |
| data_ready | input | 1 | Byte transfer finished, data register ready |
| addr_match | input | 1 | Own-address match pending |
| gcall_seen | input | 1 | Address byte 0x00 seen after a start |
| start_ok | input | 1 | Start and address phase completed successfully |
| slave_stop | input | 1 | Stop condition detected while in slave mode |
| cmd_start | output | 1 | Request to the engine to send a start when idle |
| cmd_repstart | output | 1 | One-cycle repeated-start command |
| cmd_stop | output | 1 | Request to the engine to send a stop |
| ack_value | output | 1 | Value to drive in the next acknowledge slot |
| gcall_match | output | 1 | General call accepted as a match |
| stall_flag | output | 1 | Stall-after-start status; the engine holds the bus while high |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the engine pulses `start_done`, `stop_done` and `ack_done` for a single cycle and that the status inputs are only sampled at clock edges. Under those assumptions, clearing a bit is a one-cycle consequence of the pulse. The stimulus keeps to that assumption: it changes every input just after a falling edge and holds each completion pulse for exactly one cycle. While the interrupt sweep raises `bus_err`, the start bit stays clear, so that sweep is unaffected by the clearing path. The sweep covers every combination of the seven event inputs, the four enable bits and the master state.

// File: rtl/twi_ctl_pkg.sv
package twi_ctl_pkg;

   // Field positions of the control register (decoded by software)
   localparam int unsigned BIT_START   = 0;
   localparam int unsigned BIT_STOP    = 1;
   localparam int unsigned BIT_INTEN   = 2;
   localparam int unsigned BIT_RSVD    = 3;
   localparam int unsigned BIT_ACK     = 4;
   localparam int unsigned BIT_GCEN    = 5;
   localparam int unsigned BIT_MINTEN  = 6;
   localparam int unsigned BIT_STALLEN = 7;

   localparam int unsigned CTL_W = 8;

   // Packed view, MSB first, matching the positions above
   typedef struct packed {
      logic stall_en;
      logic match_ien;
      logic gcall_en;
      logic ack_ovr;
      logic rsvd;
      logic int_en;
      logic stop_req;
      logic start_req;
   } ctl_fields_t;

   // Event sources feeding the interrupt merge
   typedef struct packed {
      logic match;
      logic berr;
      logic nack;
      logic drdy;
      logic stall;
      logic sstop;
   } irq_src_t;

   localparam int unsigned N_SRC = $bits(irq_src_t);

endpackage

// File: rtl/twi_ctl_regs.sv
module twi_ctl_regs
   import twi_ctl_pkg::*;
#(
   parameter int unsigned REG_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [REG_W-1:0] wdata,
   input  logic             start_clr,
   input  logic             stop_clr,
   input  logic             ack_clr,
   output ctl_fields_t      q
);

   // Bits loaded directly by a write: everything except reserved and ack
   localparam logic [REG_W-1:0] PLAIN_MASK =
      REG_W'((1 << BIT_START) | (1 << BIT_STOP) | (1 << BIT_INTEN) |
             (1 << BIT_GCEN) | (1 << BIT_MINTEN) | (1 << BIT_STALLEN));

   generate
      if (REG_W != CTL_W) begin : g_bad_width
         $error("twi_ctl_regs: REG_W must equal the control field width");
      end
   endgenerate

   logic [REG_W-1:0] cur;
   logic [REG_W-1:0] nxt;

   assign cur = q;

   always_comb begin
      nxt = cur;
      if (wr) begin
         nxt = (cur & ~PLAIN_MASK) | (wdata & PLAIN_MASK);
         // acknowledge override: set-only from software
         nxt[BIT_ACK] = cur[BIT_ACK] | wdata[BIT_ACK];
      end
      // hardware completion clears win over software writes
      if (start_clr) nxt[BIT_START] = 1'b0;
      if (stop_clr)  nxt[BIT_STOP]  = 1'b0;
      if (ack_clr)   nxt[BIT_ACK]   = 1'b0;
      nxt[BIT_RSVD] = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else begin
         q <= ctl_fields_t'(nxt);
      end
   end

endmodule

// File: rtl/twi_ctl_cmd.sv
module twi_ctl_cmd (
   input  logic clk,
   input  logic rst_n,
   input  logic start_req,
   input  logic stop_req,
   input  logic is_master,
   input  logic bus_busy,
   input  logic dat_wr,
   output logic cmd_start,
   output logic cmd_repstart,
   output logic cmd_stop
);

   logic rep_q;

   // Idle path: wait for a free bus before requesting a start
   assign cmd_start = start_req & ~is_master & ~bus_busy;

   // Stop only makes sense while owning the bus
   assign cmd_stop  = stop_req & is_master;

   // Active-master path: the data write carries the new address
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rep_q <= 1'b0;
      end else begin
         rep_q <= start_req & is_master & dat_wr;
      end
   end

   assign cmd_repstart = rep_q;

endmodule

// File: rtl/twi_ctl_irq.sv
module twi_ctl_irq
   import twi_ctl_pkg::*;
#(
   parameter bit IRQ_REG = 1'b0
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     int_en,
   input  irq_src_t src,
   output logic     irq
);

   logic any_src;
   logic irq_d;

   assign any_src = |src;
   assign irq_d   = int_en & any_src;

   generate
      if (IRQ_REG) begin : g_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               irq_q <= 1'b0;
            end else begin
               irq_q <= irq_d;
            end
         end
         assign irq = irq_q;
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign irq = irq_d;
      end
   endgenerate

endmodule

// File: rtl/twi_ctl_core.sv
module twi_ctl_core
   import twi_ctl_pkg::*;
#(
   parameter int unsigned REG_W   = 8,
   parameter bit          IRQ_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_wr,
   input  logic [REG_W-1:0] ctl_wdata,
   output logic [REG_W-1:0] ctl_rdata,
   input  logic             dat_wr,
   input  logic             bus_busy,
   input  logic             is_master,
   input  logic             rx_mode,
   input  logic             start_done,
   input  logic             stop_done,
   input  logic             ack_done,
   input  logic             bus_err,
   input  logic             nack_rx,
   input  logic             data_ready,
   input  logic             addr_match,
   input  logic             gcall_seen,
   input  logic             start_ok,
   input  logic             slave_stop,
   output logic             cmd_start,
   output logic             cmd_repstart,
   output logic             cmd_stop,
   output logic             ack_value,
   output logic             gcall_match,
   output logic             stall_flag,
   output logic             irq
);

   generate
      if (REG_W != CTL_W) begin : g_bad_width
         $error("twi_ctl_core: REG_W must be 8");
      end
   endgenerate

   ctl_fields_t ctl;
   irq_src_t    src;

   twi_ctl_regs #(.REG_W(REG_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (ctl_wr),
      .wdata     (ctl_wdata),
      .start_clr (start_done | bus_err),
      .stop_clr  (stop_done),
      .ack_clr   (ack_done),
      .q         (ctl)
   );

   assign ctl_rdata = ctl;

   twi_ctl_cmd u_cmd (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_req    (ctl.start_req),
      .stop_req     (ctl.stop_req),
      .is_master    (is_master),
      .bus_busy     (bus_busy),
      .dat_wr       (dat_wr),
      .cmd_start    (cmd_start),
      .cmd_repstart (cmd_repstart),
      .cmd_stop     (cmd_stop)
   );

   // Acknowledge override only matters while receiving
   assign ack_value   = ctl.ack_ovr & rx_mode;

   // General call counts only as slave and only when enabled
   assign gcall_match = gcall_seen & ctl.gcall_en & ~is_master;

   // Stall status forced low while the mechanism is disabled
   assign stall_flag  = start_ok & ctl.stall_en & is_master;

   assign src.match = (addr_match | gcall_match) & ctl.match_ien;
   assign src.berr  = bus_err;
   assign src.nack  = nack_rx;
   assign src.drdy  = data_ready;
   assign src.stall = stall_flag;
   assign src.sstop = slave_stop;

   twi_ctl_irq #(.IRQ_REG(IRQ_REG)) u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .int_en (ctl.int_en),
      .src    (src),
      .irq    (irq)
   );

endmodule

// File: rtl/twi_ctl_core_chk.sv
module twi_ctl_core_chk #(
   parameter bit IRQ_REG = 1'b0
) (
   input logic       clk,
   input logic       rst_n,
   input logic       ctl_wr,
   input logic [7:0] ctl_wdata,
   input logic [7:0] ctl_rdata,
   input logic       bus_busy,
   input logic       is_master,
   input logic       rx_mode,
   input logic       start_done,
   input logic       stop_done,
   input logic       ack_done,
   input logic       bus_err,
   input logic       gcall_seen,
   input logic       cmd_start,
   input logic       cmd_stop,
   input logic       ack_value,
   input logic       gcall_match,
   input logic       stall_flag,
   input logic       irq
);

   // R1
   rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_rdata[3] == 1'b0);

   // R2
   start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_start |-> (!bus_busy && !is_master));

   // R4
   start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_done || bus_err) |=> !ctl_rdata[0]);

   // R5
   stop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_done |=> !ctl_rdata[1]);

   // R5
   stop_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_stop |-> is_master);

   // R7
   ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_done |=> !ctl_rdata[4]);

   // R7
   ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && !ctl_wdata[4] && !ack_done && ctl_rdata[4]) |=> ctl_rdata[4]);

   // R7
   ack_rx_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_value |-> rx_mode);

   // R8
   gcall_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gcall_match |-> (gcall_seen && ctl_rdata[5] && !is_master));

   // R9
   stall_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stall_flag |-> ctl_rdata[7]);

   generate
      if (IRQ_REG) begin : g_reg
         // R6
         irq_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq |-> $past(ctl_rdata[2]));
      end else begin : g_comb
         // R6
         irq_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq |-> ctl_rdata[2]);
      end
   endgenerate

endmodule

bind twi_ctl_core twi_ctl_core_chk #(.IRQ_REG(IRQ_REG)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ctl_wr      (ctl_wr),
   .ctl_wdata   (ctl_wdata),
   .ctl_rdata   (ctl_rdata),
   .bus_busy    (bus_busy),
   .is_master   (is_master),
   .rx_mode     (rx_mode),
   .start_done  (start_done),
   .stop_done   (stop_done),
   .ack_done    (ack_done),
   .bus_err     (bus_err),
   .gcall_seen  (gcall_seen),
   .cmd_start   (cmd_start),
   .cmd_stop    (cmd_stop),
   .ack_value   (ack_value),
   .gcall_match (gcall_match),
   .stall_flag  (stall_flag),
   .irq         (irq)
);

// File: tb/twi_ctl_core_bench.sv
`timescale 1ns/1ps
module twi_ctl_core_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ctl_wr = 1'b0;
   logic [7:0] ctl_wdata = '0;
   logic [7:0] ctl_rdata;
   logic       dat_wr = 1'b0;
   logic       bus_busy = 1'b0, is_master = 1'b0, rx_mode = 1'b0;
   logic       start_done = 1'b0, stop_done = 1'b0, ack_done = 1'b0;
   logic       bus_err = 1'b0, nack_rx = 1'b0, data_ready = 1'b0;
   logic       addr_match = 1'b0, gcall_seen = 1'b0, start_ok = 1'b0;
   logic       slave_stop = 1'b0;
   logic       cmd_start, cmd_repstart, cmd_stop, ack_value;
   logic       gcall_match, stall_flag, irq;

   int n_chk = 0;
   int n_err = 0;

   always #2 clk = ~clk;

   twi_ctl_core u_twi_ctl_core (
      .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
      .ctl_rdata(ctl_rdata), .dat_wr(dat_wr), .bus_busy(bus_busy),
      .is_master(is_master), .rx_mode(rx_mode), .start_done(start_done),
      .stop_done(stop_done), .ack_done(ack_done), .bus_err(bus_err),
      .nack_rx(nack_rx), .data_ready(data_ready), .addr_match(addr_match),
      .gcall_seen(gcall_seen), .start_ok(start_ok), .slave_stop(slave_stop),
      .cmd_start(cmd_start), .cmd_repstart(cmd_repstart), .cmd_stop(cmd_stop),
      .ack_value(ack_value), .gcall_match(gcall_match),
      .stall_flag(stall_flag), .irq(irq)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   // write control register; state is visible when the task returns
   task automatic wr_ctl(input logic [7:0] d);
      @(negedge clk); ctl_wr = 1'b1; ctl_wdata = d;
      @(negedge clk); ctl_wr = 1'b0; #1;
   endtask

   task automatic settle();
      @(negedge clk); #1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      // R1 reset state
      chk("R1 reset rdata", ctl_rdata, 8'h00);
      chk("R1 reset outputs", {1'b0, cmd_start, cmd_repstart, cmd_stop,
          ack_value, gcall_match, stall_flag, irq}, 8'h00);
      rst_n = 1'b1;
      settle();
      chk("R1 idle after reset", ctl_rdata, 8'h00);

      // R1 reserved bit ignored; R2 start issued on free bus in idle
      wr_ctl(8'hFF);
      chk("R1 all-ones readback", ctl_rdata, 8'hF7);
      chk("R2 start on free bus", {7'b0, cmd_start}, 8'h01);
      bus_busy = 1'b1; #1;
      chk("R2 start held while busy", {7'b0, cmd_start}, 8'h00);
      bus_busy = 1'b0;
      chk("R5 no stop when not master", {7'b0, cmd_stop}, 8'h00);

      // R7 ack: write 0 has no effect, ignored in transmit
      wr_ctl(8'h00);
      chk("R7 ack survives write 0", ctl_rdata, 8'h10);
      rx_mode = 1'b0; #1;
      chk("R7 ack ignored in transmit", {7'b0, ack_value}, 8'h00);
      rx_mode = 1'b1; #1;
      chk("R7 ack drives nack in receive", {7'b0, ack_value}, 8'h01);
      @(negedge clk); ack_done = 1'b1;
      @(negedge clk); ack_done = 1'b0; #1;
      chk("R7 ack cleared by ack cycle", ctl_rdata, 8'h00);
      chk("R7 ack value after clear", {7'b0, ack_value}, 8'h00);
      rx_mode = 1'b0;

      // R4 clears by start_done, bus_err, and priority over a write
      wr_ctl(8'h01);
      chk("R4 start set", ctl_rdata, 8'h01);
      @(negedge clk); start_done = 1'b1;
      @(negedge clk); start_done = 1'b0; #1;
      chk("R4 start cleared by done", ctl_rdata, 8'h00);
      wr_ctl(8'h01);
      @(negedge clk); bus_err = 1'b1;
      @(negedge clk); bus_err = 1'b0; #1;
      chk("R4 start cleared by bus error", ctl_rdata, 8'h00);
      @(negedge clk); ctl_wr = 1'b1; ctl_wdata = 8'h01; start_done = 1'b1;
      @(negedge clk); ctl_wr = 1'b0; start_done = 1'b0; #1;
      chk("R4 hardware clear wins", ctl_rdata, 8'h00);

      // R3 repeated start
      is_master = 1'b1;
      @(negedge clk); dat_wr = 1'b1;
      @(negedge clk); dat_wr = 1'b0; #1;
      chk("R3 no repstart without start bit", {7'b0, cmd_repstart}, 8'h00);
      wr_ctl(8'h01);
      chk("R2 no idle start as master", {7'b0, cmd_start}, 8'h00);
      @(negedge clk); dat_wr = 1'b1;
      @(negedge clk); dat_wr = 1'b0; #1;
      chk("R3 repstart pulse", {7'b0, cmd_repstart}, 8'h01);
      settle();
      chk("R3 repstart one cycle", {7'b0, cmd_repstart}, 8'h00);
      is_master = 1'b0;
      @(negedge clk); dat_wr = 1'b1;
      @(negedge clk); dat_wr = 1'b0; #1;
      chk("R3 no repstart when not master", {7'b0, cmd_repstart}, 8'h00);
      wr_ctl(8'h00);

      // R5 stop
      is_master = 1'b1;
      wr_ctl(8'h02);
      chk("R5 stop issued as master", {7'b0, cmd_stop}, 8'h01);
      @(negedge clk); stop_done = 1'b1;
      @(negedge clk); stop_done = 1'b0; #1;
      chk("R5 stop bit cleared", ctl_rdata, 8'h00);
      chk("R5 stop command dropped", {7'b0, cmd_stop}, 8'h00);

      // R6 R8 R9 exhaustive sweep
      for (int c = 0; c < 16; c++) begin
         logic ie, mi, ge, se;
         ie = c[0]; mi = c[1]; ge = c[2]; se = c[3];
         wr_ctl({se, mi, ge, 2'b00, ie, 2'b00});
         for (int m = 0; m < 2; m++) begin
            for (int e = 0; e < 128; e++) begin
               logic x_match, x_gc, x_st, x_irq;
               @(negedge clk);
               is_master  = m[0];
               addr_match = e[0]; gcall_seen = e[1]; bus_err = e[2];
               nack_rx    = e[3]; data_ready = e[4]; start_ok = e[5];
               slave_stop = e[6];
               #1;
               x_gc    = e[1] & ge & ~m[0];
               x_st    = e[5] & se & m[0];
               x_match = e[0] | x_gc;
               x_irq   = ie & ((x_match & mi) | e[2] | e[3] | e[4] | x_st | e[6]);
               chk("R8 general call gate", {7'b0, gcall_match}, {7'b0, x_gc});
               chk("R9 stall flag gate", {7'b0, stall_flag}, {7'b0, x_st});
               chk("R6 interrupt merge", {7'b0, irq}, {7'b0, x_irq});
            end
         end
      end
      @(negedge clk);
      {addr_match, gcall_seen, bus_err, nack_rx, data_ready, start_ok, slave_stop} = '0;
      settle();

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule